// File: doc/BRIEF.md
# Pulse-Width Bit Decoder

This block turns a pulse-width-modulated serial line back into a stream of bits. Each bit period on the line opens with a rising edge, and these edges arrive at a steady rate. A short high pulse stands for a 0 and a long high pulse stands for a 1. The block counts system clock cycles from each rising edge. When the count reaches a programmable threshold, it takes a single sample of the line. That sampled level is the decoded bit, and it is presented together with a one-cycle valid strobe.

The line is first passed through a synchronizer. Edge detection and sampling both use the synchronized copy. The threshold register can be written at any time, but a new value only takes effect at the next bit period. A stop control holds the counter and the decoder idle. The block comes out of reset stopped, and it starts decoding once the stop control is written to 0.

Top module: `pulse_bit_decoder`

## Requirements
- R1: After reset, bit_out is 0, bit_valid is 0, and the block is stopped.
- R2: While stopped (last stop write had stop_wdata=1, or reset), bit_valid stays 0 and bit_out holds its value, including for a period already in progress. After stop_wdata=0 is written, decoding resumes from the next rising edge of the line.
- R3: Let the clock edge where pwm_in is first sampled high be edge a, and let the active threshold be T. The decoded bit is the level of pwm_in sampled at edge a+T+1. bit_out takes this value, and bit_valid is high, in the cycle after edge a+T+3. For a pulse that is high for H samples, the bit is 1 exactly when H > T+1.
- R4: bit_valid is high for one cycle only, and it fires at most once per bit period.
- R5: The cycle counter saturates at 2^CNT_W-1 and does not wrap. If no further rising edge arrives, no second bit_valid follows, even for more than 2^CNT_W cycles.
- R6: The active threshold is loaded from the threshold register (written via thr_we/thr_wdata) only on a detected rising edge. A write made during a period affects the next period only; a write in the same cycle as the load edge is not taken.
- R7: If a rising edge is detected in the same cycle as the threshold match of the running period, the new period wins. That period gives no bit_valid.
- R8: Threshold values 0 and 2^CNT_W-1 both decode according to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Asynchronous pulse-width-modulated line |
| thr_we | input | 1 | Threshold register write enable |
| thr_wdata | input | CNT_W | Threshold value in clock cycles |
| stop_we | input | 1 | Stop control write enable |
| stop_wdata | input | 1 | 1 stops the decoder, 0 runs it |
| bit_out | output | 1 | Last decoded bit |
| bit_valid | output | 1 | One-cycle strobe marking a new bit_out |

## Verification
The threshold match that ends a period's decision and the rising edge that starts the next period can fall in the same cycle. The bench provokes this by sending periods exactly T+1 cycles long, so that every new edge is detected in the cycle where the old count equals T. It judges the result by requiring that bit_valid never rises during that run. The next longer period must then decode normally. Sweeps over thresholds and pulse widths cover the normal decision timing around this corner.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

    typedef enum logic {
        RUN_ACTIVE  = 1'b0,
        RUN_STOPPED = 1'b1
    } run_mode_t;

    // Synchronized line view handed from the synchronizer to the counter.
    typedef struct packed {
        logic level;
        logic rise;
    } line_evt_t;

    // Compare-match strobe plus the line level at that instant.
    typedef struct packed {
        logic strobe;
        logic level;
    } sample_t;

    localparam int unsigned SYNC_STAGES_DEF = 2;

    function automatic logic edge_up(input logic now_lvl, input logic old_lvl);
        return now_lvl & ~old_lvl;
    endfunction

    function automatic run_mode_t mode_from_bit(input logic stop_bit);
        return stop_bit ? RUN_STOPPED : RUN_ACTIVE;
    endfunction

endpackage

// File: rtl/pbd_sync.sv
module pbd_sync
    import pbd_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pwm_in,
    output line_evt_t evt
);
    logic [STAGES-1:0] chain;
    logic              last_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain    <= '0;
            last_lvl <= 1'b0;
        end else begin
            chain    <= {chain[STAGES-2:0], pwm_in};
            last_lvl <= chain[STAGES-1];
        end
    end

    always_comb begin
        evt.level = chain[STAGES-1];
        evt.rise  = edge_up(chain[STAGES-1], last_lvl);
    end

endmodule

// File: rtl/pbd_counter.sv
module pbd_counter
    import pbd_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned THR_RST = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  run_mode_t        mode,
    input  line_evt_t        evt,
    input  logic             thr_we,
    input  logic [CNT_W-1:0] thr_wdata,
    output sample_t          smp
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] THR_INIT = CNT_W'(THR_RST);

    logic [CNT_W-1:0] thr_reg;
    logic [CNT_W-1:0] thr_act;
    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             running;
    logic             hit;

    assign running = (mode == RUN_ACTIVE);
    assign hit     = running & armed & ~evt.rise & (cnt == thr_act);

    // Programmer-visible threshold, writable at any time.
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_reg <= THR_INIT;
        end else if (thr_we) begin
            thr_reg <= thr_wdata;
        end
    end

    // Period counter; an edge restarts it and loads the active threshold.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            armed   <= 1'b0;
            thr_act <= THR_INIT;
        end else if (!running) begin
            cnt     <= '0;
            armed   <= 1'b0;
        end else if (evt.rise) begin
            cnt     <= '0;
            armed   <= 1'b1;
            thr_act <= thr_reg;
        end else begin
            if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
            if (hit) begin
                armed <= 1'b0;
            end
        end
    end

    always_comb begin
        smp.strobe = hit;
        smp.level  = evt.level;
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (running && !evt.rise && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R5

    AST_THR_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !(running && evt.rise) |=> $stable(thr_act)); // R6

endmodule

// File: rtl/pbd_latch.sv
module pbd_latch
    import pbd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  run_mode_t mode,
    input  sample_t   smp,
    output logic      bit_out,
    output logic      bit_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
        end else begin
            bit_valid <= smp.strobe;
            if (smp.strobe) begin
                bit_out <= smp.level;
            end
        end
    end

    AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |-> $stable(bit_out)); // R3

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid); // R4

    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mode == RUN_STOPPED) |=> !bit_valid); // R2

endmodule

// File: rtl/pulse_bit_decoder.sv
module pulse_bit_decoder
    import pbd_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned THR_RST     = 0,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_in,
    input  logic             thr_we,
    input  logic [CNT_W-1:0] thr_wdata,
    input  logic             stop_we,
    input  logic             stop_wdata,
    output logic             bit_out,
    output logic             bit_valid
);
    run_mode_t mode;
    line_evt_t evt;
    sample_t   smp;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= RUN_STOPPED;
        end else if (stop_we) begin
            mode <= mode_from_bit(stop_wdata);
        end
    end

    pbd_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pwm_in (pwm_in),
        .evt    (evt)
    );

    pbd_counter #(
        .CNT_W   (CNT_W),
        .THR_RST (THR_RST)
    ) u_counter (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .evt       (evt),
        .thr_we    (thr_we),
        .thr_wdata (thr_wdata),
        .smp       (smp)
    );

    pbd_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .smp       (smp),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );

    AST_EDGE_BEATS_MATCH: assert property (@(posedge clk) disable iff (rst)
        (evt.rise && mode == RUN_ACTIVE) |=> !bit_valid); // R7

endmodule

// File: tb/test_pulse_bit_decoder.sv
module test_pulse_bit_decoder;

    localparam int W    = 4;
    localparam int TMAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pwm_in = 1'b0;
    logic         thr_we = 1'b0;
    logic [W-1:0] thr_wdata = '0;
    logic         stop_we = 1'b0;
    logic         stop_wdata = 1'b1;
    logic         bit_out;
    logic         bit_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pulse_bit_decoder #(
        .CNT_W   (W),
        .THR_RST (5)
    ) i_pulse_bit_decoder (
        .clk        (clk),
        .rst        (rst),
        .pwm_in     (pwm_in),
        .thr_we     (thr_we),
        .thr_wdata  (thr_wdata),
        .stop_we    (stop_we),
        .stop_wdata (stop_wdata),
        .bit_out    (bit_out),
        .bit_valid  (bit_valid)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            pwm_in = 1'b0; thr_we = 1'b0; stop_we = 1'b0;
        end
    endtask

    task automatic write_thr(input int v);
        @(negedge clk);
        pwm_in = 1'b0; thr_we = 1'b1; thr_wdata = W'(v);
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    task automatic write_stop(input logic b);
        @(negedge clk);
        pwm_in = 1'b0; stop_we = 1'b1; stop_wdata = b;
        @(negedge clk);
        stop_we = 1'b0;
    endtask

    // One bit period: high for h samples out of p. Outputs seen at iteration i
    // reflect the edge before sample i; a decision lands at i = thr+4.
    task automatic period(input string req, input int thr, input int h, input int p,
                          input bit expect_bit, input int wr_at, input int wr_val,
                          input int stop_at);
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            if (i > 0) begin
                logic ev;
                ev = expect_bit && (i == thr + 4);
                check(req, $sformatf("valid thr=%0d h=%0d i=%0d", thr, h, i), bit_valid, ev);
                if (ev)
                    check(req, $sformatf("bit thr=%0d h=%0d", thr, h), bit_out, logic'(h > thr + 1));
            end
            pwm_in  = (i < h);
            thr_we  = (i == wr_at);
            if (i == wr_at) thr_wdata = W'(wr_val);
            stop_we = (i == stop_at);
            if (i == stop_at) stop_wdata = 1'b1;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "reset bit_out", bit_out, 1'b0);
        check("R1", "reset bit_valid", bit_valid, 1'b0);

        // R2: stopped out of reset, full period produces nothing
        idle(2);
        period("R2", 5, 10, 14, 1'b0, -1, 0, -1);
        idle(6);
        check("R2", "bit_out while stopped", bit_out, 1'b0);
        check("R2", "valid while stopped", bit_valid, 1'b0);

        write_stop(1'b0);
        idle(3);

        // R3: sweep threshold against pulse width
        for (int t = 0; t <= 9; t++) begin
            write_thr(t);
            idle(2);
            for (int h = 1; h <= t + 6; h++)
                period("R3", t, h, t + 7, 1'b1, -1, 0, -1);
        end

        // R8: both threshold extremes
        write_thr(0); idle(2);
        period("R8", 0, 1, 7, 1'b1, -1, 0, -1);
        period("R8", 0, 2, 7, 1'b1, -1, 0, -1);
        write_thr(TMAX); idle(2);
        period("R8", TMAX, 16, 25, 1'b1, -1, 0, -1);
        period("R8", TMAX, 17, 25, 1'b1, -1, 0, -1);
        period("R8", TMAX, 20, 25, 1'b1, -1, 0, -1);

        // R5: long periods past the counter range give exactly one strobe
        period("R5", TMAX, 3, 60, 1'b1, -1, 0, -1);
        write_thr(2); idle(2);
        period("R5", 2, 30, 60, 1'b1, -1, 0, -1);

        // R6: write mid-period applies at the next edge only
        period("R6", 2, 6, 16, 1'b1, 3, 8, -1);
        period("R6", 8, 6, 16, 1'b1, -1, 0, -1);
        period("R6", 8, 11, 16, 1'b1, -1, 0, -1);

        // R7: period of thr+1 cycles puts every edge on the match cycle
        write_thr(3); idle(2);
        for (int k = 0; k < 6; k++)
            period("R7", 3, 2, 4, 1'b0, -1, 0, -1);
        period("R7", 3, 2, 10, 1'b1, -1, 0, -1);
        period("R4", 3, 9, 10, 1'b1, -1, 0, -1);
        idle(8);
        check("R4", "no repeat strobe", bit_valid, 1'b0);

        // R2: stop in the middle of a period keeps the previous bit
        period("R2", 3, 2, 12, 1'b0, -1, 0, 2);
        idle(4);
        check("R2", "bit held after stop", bit_out, 1'b1);
        write_stop(1'b0);
        idle(3);
        period("R2", 3, 2, 12, 1'b1, -1, 0, -1);
        period("R2", 3, 9, 12, 1'b1, -1, 0, -1);

        idle(4);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule